// File: doc/BRIEF.md
# Signed/Unsigned Arithmetic Unit with Modulo-3

This block is a purely combinational arithmetic unit for two operands of a configurable width (eight bits by default). A four-bit function code picks the operation: pass either operand straight through, add, subtract, or reduce the first operand modulo 3. Every arithmetic operation comes in two versions. One treats the operands as unsigned binary numbers. The other treats them as two's complement numbers. The top bit of the function code picks the signed version.

The unit returns a result of operand width, an overflow flag and a sign flag. The overflow flag uses the rule that matches the chosen interpretation. The sign flag is meant for a display stage further on. The modulo-3 path has no divider. It adds up two-bit digits, which works because 4 leaves remainder 1 when divided by 3. It then brings that small sum down with conditional subtractions of scaled multiples of 3. A constant correction turns the result into the mathematical remainder 0..2 when a signed operand is negative.

Top module: `mod3_alu`

## Requirements
- R1: Code 0000 puts operand A on the result and code 0001 puts operand B on the result. In both cases overflow and sign are 0.
- R2: Code 0010 gives (A+B) modulo 2^W on the result. Overflow equals the carry out of the top bit.
- R3: Code 0011 gives (A−B) modulo 2^W on the result. Overflow is 1 exactly when A < B as unsigned numbers.
- R4: Code 0100 gives the unsigned value of A modulo 3 (0, 1 or 2) on the result. Overflow is 0.
- R5: Code 1010 gives the two's complement sum on the result. Overflow is 1 exactly when A and B have the same top bit and the result's top bit differs from it.
- R6: Code 1011 gives the two's complement difference A−B on the result. Overflow is 1 exactly when the top bits of A and B differ and the result's top bit differs from A's.
- R7: Code 1100 treats A as a two's complement number and gives its mathematical remainder modulo 3, always in 0..2 (for example −1 gives 2). Overflow is 0.
- R8: For codes 1010 and 1011 the sign flag equals the result's top bit. For code 1100 and for every unsigned or pass code the sign flag is 0.
- R9: Any code other than the eight listed in R1–R7 gives a result of 0, overflow 0 and sign 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | DATA_W | First operand |
| opd_b | input | DATA_W | Second operand |
| fn_code | input | 4 | Function code; bit 3 selects signed interpretation |
| result | output | DATA_W | Operation result |
| ovf | output | 1 | Overflow for the selected interpretation |
| neg_flag | output | 1 | Sign of a signed add/subtract result |

## Verification
The bench builds the unit with DATA_W = 6. At that width it can apply all sixteen function codes to every one of the 4096 operand pairs in one run. Every carry, borrow and two's complement overflow boundary is therefore reached, including the most negative operand and its negation. The modulo-3 digit sum, its reduction stages and the negative correction are also covered for every possible operand. The expected values come from integer arithmetic on the sign-extended operands.

// File: rtl/mod3_alu_pkg.sv
// Shared types for the arithmetic unit: the internal operation code and the
// decoded form of the four-bit function code.
package mod3_alu_pkg;

    // Internal operation, taken from the low three bits of the function code
    typedef enum logic [2:0] {
        OP_PASS_A = 3'b000,
        OP_PASS_B = 3'b001,
        OP_ADD    = 3'b010,
        OP_SUB    = 3'b011,
        OP_MOD3   = 3'b100
    } op_e;

    // Decoded function code
    typedef struct packed {
        op_e  op;
        logic is_signed;
        logic valid;
    } fn_dec_t;

endpackage

// File: rtl/mod3_alu_decode.sv
// Function-code decoder.
// Turns the four-bit code into an operation, a signed flag and a valid flag.
// Assumes nothing about the input: every code outside the eight defined ones
// comes out as valid = 0.
module mod3_alu_decode
    import mod3_alu_pkg::*;
(
    input  logic [3:0] fn_code,
    output fn_dec_t    dec
);

    // Table lookup of the eight defined codes
    always_comb begin
        dec.op        = OP_PASS_A;
        dec.is_signed = 1'b0;
        dec.valid     = 1'b0;
        case (fn_code)
            4'b0000: begin dec.op = OP_PASS_A; dec.valid = 1'b1; end
            4'b0001: begin dec.op = OP_PASS_B; dec.valid = 1'b1; end
            4'b0010: begin dec.op = OP_ADD;    dec.valid = 1'b1; end
            4'b0011: begin dec.op = OP_SUB;    dec.valid = 1'b1; end
            4'b0100: begin dec.op = OP_MOD3;   dec.valid = 1'b1; end
            4'b1010: begin dec.op = OP_ADD;    dec.valid = 1'b1; dec.is_signed = 1'b1; end
            4'b1011: begin dec.op = OP_SUB;    dec.valid = 1'b1; dec.is_signed = 1'b1; end
            4'b1100: begin dec.op = OP_MOD3;   dec.valid = 1'b1; dec.is_signed = 1'b1; end
            default: begin dec.valid = 1'b0; end
        endcase
    end

    // The signed bit of a defined code always matches bit 3 (R8)
    always_comb begin
        if (!$isunknown(fn_code) && dec.valid)
            assert (dec.is_signed == fn_code[3])
                else $error("p_signed_bit_r8: decoded signed flag disagrees with code");
    end

endmodule

// File: rtl/mod3_alu_addsub.sv
// Shared adder/subtractor.
// Subtraction adds the inverted second operand plus a carry-in of one.
// Overflow follows the unsigned rule (carry or borrow) or the two's
// complement rule, depending on is_signed. Assumes W >= 2.
module mod3_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         is_signed,
    output logic [W-1:0] sum,
    output logic         ovf
);

    localparam int TOP = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   raw;
    logic         carry;

    // Condition the second operand and form the wide sum
    always_comb begin
        b_eff = sub ? ~b : b;
        raw   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = raw[W-1:0];
        carry = raw[W];
    end

    // Overflow: carry/borrow when unsigned, sign rule when signed
    always_comb begin
        if (is_signed)
            ovf = (a[TOP] == b_eff[TOP]) && (sum[TOP] != a[TOP]);
        else
            ovf = sub ? ~carry : carry;
    end

    // Reference overflow from a sign-extended computation one bit wider
    logic [W:0] wide_ref;
    always_comb begin
        wide_ref = sub ? ({a[TOP], a} - {b[TOP], b}) : ({a[TOP], a} + {b[TOP], b});
    end

    // Unsigned borrow agrees with a magnitude comparison (R3)
    always_comb begin
        if (!$isunknown({a, b, sub, is_signed}) && sub && !is_signed)
            assert (ovf == (a < b))
                else $error("p_borrow_r3: unsigned borrow mismatch");
    end

    // Signed overflow agrees with the wide reference (R5, R6)
    always_comb begin
        if (!$isunknown({a, b, sub, is_signed}) && is_signed)
            assert (ovf == (wide_ref[W] != wide_ref[TOP]))
                else $error("p_signed_ovf_r5: signed overflow mismatch (R6 for subtract)");
    end

endmodule

// File: rtl/mod3_alu_mod3.sv
// Modulo-3 reducer without a divider.
// Step 1: sum the two-bit digits of the operand (4 leaves remainder 1 mod 3).
// Step 2: conditionally subtract 3*2^k for k from high to low, which leaves a
//         value in 0..2.
// Step 3: for a negative signed operand, subtract the constant 2^W mod 3 and
//         wrap into 0..2.
// Assumes W >= 2.
module mod3_alu_mod3 #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         is_signed,
    output logic [1:0]   rem
);

    localparam int ND = (W + 1) / 2;            // number of two-bit digits
    localparam int PW = 2 * ND;                 // padded operand width
    localparam int SW = $clog2(3 * ND + 1);     // digit-sum width
    localparam int KS = $clog2(ND + 1);         // reduction stages
    localparam logic [1:0] WRAP = (W % 2 == 0) ? 2'd1 : 2'd2;  // 2^W mod 3

    logic [PW-1:0] ap;
    logic [SW-1:0] acc [0:ND];
    logic [SW-1:0] red [0:KS];
    logic [1:0]    urem;

    // Zero-pad the operand to a whole number of digits
    always_comb begin
        ap = '0;
        ap[W-1:0] = a;
    end

    assign acc[0] = '0;

    // Running sum of the digits
    for (genvar i = 0; i < ND; i++) begin : g_digit
        assign acc[i+1] = acc[i] + SW'(ap[2*i +: 2]);
    end

    assign red[KS] = acc[ND];

    // Binary restoring reduction by multiples of three
    for (genvar k = KS - 1; k >= 0; k--) begin : g_reduce
        localparam logic [SW-1:0] STEP = SW'(3 << k);
        assign red[k] = (red[k+1] >= STEP) ? (red[k+1] - STEP) : red[k+1];
    end

    assign urem = red[0][1:0];

    // Correction of a negative two's complement operand
    always_comb begin
        if (is_signed && a[W-1])
            rem = (urem >= WRAP) ? (urem - WRAP) : (urem + 2'd3 - WRAP);
        else
            rem = urem;
    end

    // Reduction leaves a value in 0..2 and the upper bits clear (R4)
    always_comb begin
        if (!$isunknown(a))
            assert (red[0] < SW'(3))
                else $error("p_reduced_range_r4: reduction left %0d", red[0]);
    end

    // Final remainder is always in 0..2 (R7)
    always_comb begin
        if (!$isunknown({a, is_signed}))
            assert (rem != 2'd3)
                else $error("p_rem_range_r7: remainder out of range");
    end

endmodule

// File: rtl/mod3_alu.sv
// Top of the arithmetic unit.
// Decodes the function code, runs the shared adder/subtractor and the mod-3
// reducer in parallel, and selects the result and flags. Fully
// combinational; assumes DATA_W >= 2.
module mod3_alu
    import mod3_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opd_a,
    input  logic [DATA_W-1:0] opd_b,
    input  logic [3:0]        fn_code,
    output logic [DATA_W-1:0] result,
    output logic              ovf,
    output logic              neg_flag
);

    localparam int TOP = DATA_W - 1;

    fn_dec_t           dec;
    logic [DATA_W-1:0] as_sum;
    logic              as_ovf;
    logic [1:0]        m3;
    logic              is_sub;

    mod3_alu_decode u_dec (
        .fn_code (fn_code),
        .dec     (dec)
    );

    assign is_sub = (dec.op == OP_SUB);

    mod3_alu_addsub #(.W(DATA_W)) u_addsub (
        .a         (opd_a),
        .b         (opd_b),
        .sub       (is_sub),
        .is_signed (dec.is_signed),
        .sum       (as_sum),
        .ovf       (as_ovf)
    );

    mod3_alu_mod3 #(.W(DATA_W)) u_mod3 (
        .a         (opd_a),
        .is_signed (dec.is_signed),
        .rem       (m3)
    );

    // Select result and overflow by operation
    always_comb begin
        result = '0;
        ovf    = 1'b0;
        if (dec.valid) begin
            case (dec.op)
                OP_PASS_A: result = opd_a;
                OP_PASS_B: result = opd_b;
                OP_ADD, OP_SUB: begin
                    result = as_sum;
                    ovf    = as_ovf;
                end
                OP_MOD3:   result = DATA_W'(m3);
                default:   result = '0;
            endcase
        end
    end

    // Sign flag only for signed add/subtract
    always_comb begin
        neg_flag = dec.valid && dec.is_signed && (dec.op != OP_MOD3) && result[TOP];
    end

    // Undefined codes give zero outputs (R9)
    always_comb begin
        if (!$isunknown(fn_code) && !dec.valid)
            assert (result == '0 && !ovf && !neg_flag)
                else $error("p_unused_zero_r9: undefined code gave nonzero outputs");
    end

    // Mod-3 operations never flag overflow (R4, R7)
    always_comb begin
        if (!$isunknown(fn_code) && fn_code[2:0] == 3'b100)
            assert (!ovf)
                else $error("p_mod_no_ovf_r7: overflow set on mod-3 code");
    end

    // Unsigned codes never raise the sign flag (R8)
    always_comb begin
        if (!$isunknown(fn_code) && !fn_code[3])
            assert (!neg_flag)
                else $error("p_unsigned_no_sign_r8: sign flag on unsigned code");
    end

    // Pass codes report no overflow (R1)
    always_comb begin
        if (!$isunknown(fn_code) && fn_code[3:1] == 3'b000)
            assert (!ovf)
                else $error("p_pass_no_ovf_r1: overflow set on pass code");
    end

endmodule

// File: tb/sim_mod3_alu.sv
// Exhaustive bench: all sixteen codes over all operand pairs at width 6.
module sim_mod3_alu;

    localparam int W     = 6;
    localparam int MASK  = (1 << W) - 1;
    localparam int SMAX  = (1 << (W - 1)) - 1;
    localparam int SMIN  = -(1 << (W - 1));
    localparam int LIMIT = 100000;

    logic         clk = 1'b0;
    logic [W-1:0] a, b;
    logic [3:0]   fn;
    logic [W-1:0] result;
    logic         ovf, neg_flag;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    mod3_alu #(.DATA_W(W)) u0 (
        .opd_a    (a),
        .opd_b    (b),
        .fn_code  (fn),
        .result   (result),
        .ovf      (ovf),
        .neg_flag (neg_flag)
    );

    function automatic string tag_of(input int code);
        case (code)
            0, 1:    return "R1";
            2:       return "R2";
            3:       return "R3";
            4:       return "R4";
            10:      return "R5";
            11:      return "R6";
            12:      return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(input int code, input int ia, input int ib);
        int sa, sb, s, er, eo, es;
        @(posedge clk);
        fn = 4'(code);
        a  = W'(ia);
        b  = W'(ib);
        sa = (ia > SMAX) ? ia - (1 << W) : ia;
        sb = (ib > SMAX) ? ib - (1 << W) : ib;
        er = 0; eo = 0; es = 0;
        case (code)
            0:  er = ia;
            1:  er = ib;
            2:  begin s = ia + ib; er = s & MASK; eo = (s > MASK) ? 1 : 0; end
            3:  begin er = (ia - ib) & MASK; eo = (ia < ib) ? 1 : 0; end
            4:  er = ia % 3;
            10: begin s = sa + sb; er = s & MASK; eo = (s > SMAX || s < SMIN) ? 1 : 0;
                      es = (er >> (W - 1)) & 1; end
            11: begin s = sa - sb; er = s & MASK; eo = (s > SMAX || s < SMIN) ? 1 : 0;
                      es = (er >> (W - 1)) & 1; end
            12: er = ((sa % 3) + 3) % 3;
            default: begin er = 0; eo = 0; es = 0; end
        endcase
        @(negedge clk);
        vectors++;
        if (int'(result) != er || int'(ovf) != eo) begin
            fails++;
            $display("FAIL %s code=%0d a=%0d b=%0d result/ovf actual %0d/%0d expected %0d/%0d",
                     tag_of(code), code, ia, ib, result, ovf, er, eo);
        end else if (int'(neg_flag) != es) begin
            fails++;
            $display("FAIL R8 code=%0d a=%0d b=%0d sign actual %0d expected %0d",
                     code, ia, ib, neg_flag, es);
        end
    endtask

    initial begin
        fn = 4'd0; a = '0; b = '0;
        // Start-up state: pass A of zero gives all-zero outputs (R1)
        apply(0, 0, 0);
        // Boundary picks: signed corner overflow (R5, R6), -1 mod 3 (R7)
        apply(10, SMAX, 1);
        apply(11, 1 << (W - 1), 1);
        apply(12, MASK, 0);
        apply(3, 0, 1);
        // Full sweep over every code and operand pair (R1 to R9 each)
        for (int c = 0; c < 16; c++)
            for (int x = 0; x <= MASK; x++)
                for (int y = 0; y <= MASK; y++)
                    apply(c, x, y);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule